// File: doc/BRIEF.md
# Paged Circular Address Generator

This block computes data-memory addresses for a processor datapath. It keeps four 16-bit index pointers, each paired with a modify, a length and a base register. An 8-bit page register supplies the top byte of every 24-bit address it emits. On each operation the selected pointer is offset by either a modify register or a sign-extended 8-bit immediate. The block then either emits the offset value and leaves the pointer alone (pre-modify), or emits the pointer and stores the offset value back (post-modify). A third operation only updates the pointer and makes no memory access.

A pointer whose length register is nonzero walks a circular buffer. The buffer starts at the pointer's base register, which may be any 16-bit value, and is confined to the current 64K page. A length of zero gives plain 16-bit wraparound. The emitted 16-bit word can be bit-mirrored for FFT-style reordering. A complete second register set, with its own page register, can be exchanged with the working set in one cycle for a fast context switch. Registers are loaded through a single write port and read back through a combinational read port.

Top module: `paged_dag`

## Requirements
- R1: While rst_n is low, every register of both sets becomes zero. After reset is released, `addr_valid` is low unless an access is requested.
- R2: With `op_code`=0 (pre-modify), `addr_valid` is high and `addr[15:0]` equals the wrapped sum of index and modifier in the same cycle. The index register is left unchanged.
- R3: With `op_code`=1 (post-modify), `addr_valid` is high and `addr[15:0]` equals the current index. The wrapped sum is stored in the index register at the clock edge.
- R4: With `imm_sel`=1 the modifier is `imm` read as 8-bit two's complement and sign-extended to 16 bits. With `imm_sel`=0 it is the modify register chosen by `mod_sel`.
- R5: With `op_code`=2 the index register is updated as in R3 and `addr_valid` stays low. `op_code`=3 changes no register and leaves `addr_valid` low.
- R6: When the selected length L is nonzero, an offset sum at or above base+L has L subtracted, and a sum below base has L added. This holds for modifiers whose magnitude is below L.
- R7: When the selected length is zero, the sum wraps modulo 2^16.
- R8: `addr[23:16]` is the page register. A value written with `page_wr` appears on `addr` from the next cycle on.
- R9: With `bitrev`=1, output bit k of `addr[15:0]` is bit 15-k of the 16-bit word otherwise emitted. The stored index is not affected.
- R10: A `swap` pulse exchanges the working and shadow register sets, page included, at the clock edge. An operation in that same cycle is computed from the working set before the exchange, and its write-back travels into the shadow set.
- R11: A port write to a register takes priority over an index update of the same register in the same cycle. `rd_file` codes 0/1/2/3 select index/modify/length/base of the working set, and `rd_data` shows that register combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_code | input | 2 | 0 pre-modify, 1 post-modify, 2 modify only, 3 none |
| op_sel | input | 2 | Index pointer used by the operation |
| imm_sel | input | 1 | 1 selects the immediate modifier |
| mod_sel | input | 2 | Modify register used when imm_sel is 0 |
| imm | input | 8 | Signed immediate modifier |
| bitrev | input | 1 | Mirror the emitted 16-bit word |
| wr_en | input | 1 | Register write strobe |
| wr_file | input | 2 | 0 index, 1 modify, 2 length, 3 base |
| wr_sel | input | 2 | Register number to write |
| wr_data | input | 16 | Write data |
| page_wr | input | 1 | Page register write strobe |
| page_data | input | 8 | Page register write data |
| swap | input | 1 | Exchange working and shadow sets |
| rd_file | input | 2 | Read file select, same codes as wr_file |
| rd_sel | input | 2 | Register number to read |
| rd_data | output | 16 | Selected working register |
| addr_valid | output | 1 | An address is being emitted |
| addr | output | 24 | Page byte followed by the 16-bit address |

## Verification
A post-modify write-back can meet either a port write to the same index register or a set swap in the same cycle. The bench provokes both by driving the write strobe or the swap pulse together with a post-modify on pointer 0. In each case it samples the emitted address in that cycle, which must come from the old value. It then reads the index back after the edge. The port write's value must win. After a swap, the write-back must surface only when the sets are swapped back again.

// File: rtl/dagp_pkg.sv
// Shared encodings for the paged circular address generator.
package dagp_pkg;
    typedef enum logic [1:0] {
        OP_PRE  = 2'd0,
        OP_POST = 2'd1,
        OP_MOD  = 2'd2,
        OP_NONE = 2'd3
    } dag_op_e;

    typedef enum logic [1:0] {
        RF_INDEX  = 2'd0,
        RF_MODIFY = 2'd1,
        RF_LENGTH = 2'd2,
        RF_BASE   = 2'd3
    } dag_file_e;
endpackage

// File: rtl/dagp_bank.sv
// Working and shadow register sets: index, modify, length, base and page.
// Assumes one port write and one index update per cycle; the port write
// wins on a clash. A swap moves the updated working set into the shadow.
module dagp_bank
    import dagp_pkg::*;
#(
    parameter int AW   = 16,
    parameter int PW   = 8,
    parameter int NREG = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [1:0]              wr_file,
    input  logic [$clog2(NREG)-1:0] wr_sel,
    input  logic [AW-1:0]           wr_data,
    input  logic                    page_wr,
    input  logic [PW-1:0]           page_data,
    input  logic                    upd_en,
    input  logic [$clog2(NREG)-1:0] upd_sel,
    input  logic [AW-1:0]           upd_val,
    input  logic                    swap,
    output logic [AW-1:0]           idx_o  [NREG],
    output logic [AW-1:0]           mod_o  [NREG],
    output logic [AW-1:0]           len_o  [NREG],
    output logic [AW-1:0]           base_o [NREG],
    output logic [PW-1:0]           page_o,
    output logic [AW-1:0]           sec_idx_o [NREG]
);
    logic [AW-1:0] pri_i [NREG], pri_m [NREG], pri_l [NREG], pri_b [NREG];
    logic [AW-1:0] sec_i [NREG], sec_m [NREG], sec_l [NREG], sec_b [NREG];
    logic [AW-1:0] nxt_i [NREG], nxt_m [NREG], nxt_l [NREG], nxt_b [NREG];
    logic [PW-1:0] pri_p, sec_p, nxt_p;

    // Next working set: index update first, then port write on top.
    always_comb begin
        nxt_i = pri_i;
        nxt_m = pri_m;
        nxt_l = pri_l;
        nxt_b = pri_b;
        nxt_p = page_wr ? page_data : pri_p;
        if (upd_en) nxt_i[upd_sel] = upd_val;
        if (wr_en) begin
            case (dag_file_e'(wr_file))
                RF_INDEX:  nxt_i[wr_sel] = wr_data;
                RF_MODIFY: nxt_m[wr_sel] = wr_data;
                RF_LENGTH: nxt_l[wr_sel] = wr_data;
                default:   nxt_b[wr_sel] = wr_data;
            endcase
        end
    end

    // Register both sets; a swap exchanges them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < NREG; k++) begin
                pri_i[k] <= '0; pri_m[k] <= '0; pri_l[k] <= '0; pri_b[k] <= '0;
                sec_i[k] <= '0; sec_m[k] <= '0; sec_l[k] <= '0; sec_b[k] <= '0;
            end
            pri_p <= '0;
            sec_p <= '0;
        end else if (swap) begin
            pri_i <= sec_i; pri_m <= sec_m; pri_l <= sec_l; pri_b <= sec_b;
            sec_i <= nxt_i; sec_m <= nxt_m; sec_l <= nxt_l; sec_b <= nxt_b;
            pri_p <= sec_p;
            sec_p <= nxt_p;
        end else begin
            pri_i <= nxt_i; pri_m <= nxt_m; pri_l <= nxt_l; pri_b <= nxt_b;
            pri_p <= nxt_p;
        end
    end

    assign idx_o     = pri_i;
    assign mod_o     = pri_m;
    assign len_o     = pri_l;
    assign base_o    = pri_b;
    assign page_o    = pri_p;
    assign sec_idx_o = sec_i;
endmodule

// File: rtl/dagp_wrap.sv
// Adds a signed modifier to an index and folds the sum into the circular
// buffer [base, base+len). Assumes |modifier| < len and that the buffer does
// not cross the 64K page. len of zero gives plain modulo-2^AW arithmetic.
module dagp_wrap #(
    parameter int AW = 16
) (
    input  logic [AW-1:0] idx_i,
    input  logic [AW-1:0] mod_i,
    input  logic [AW-1:0] base_i,
    input  logic [AW-1:0] len_i,
    output logic [AW-1:0] nxt_o
);
    localparam int EW = AW + 2;

    logic signed [EW-1:0] sum_s, lo_s, hi_s, len_s, fix_s;

    assign len_s = $signed({2'b00, len_i});
    assign lo_s  = $signed({2'b00, base_i});
    assign hi_s  = lo_s + len_s;
    assign sum_s = $signed({2'b00, idx_i}) + $signed({{2{mod_i[AW-1]}}, mod_i});

    // Fold the sum back into the buffer window when circular mode is on.
    always_comb begin
        fix_s = sum_s;
        if (len_i != '0) begin
            if (sum_s >= hi_s)     fix_s = sum_s - len_s;
            else if (sum_s < lo_s) fix_s = sum_s + len_s;
        end
    end

    assign nxt_o = fix_s[AW-1:0];
endmodule

// File: rtl/dagp_fmt.sv
// Forms the full address from the page byte and the 16-bit word, with an
// optional mirror of the word. REV_EN=0 removes the mirror hardware.
module dagp_fmt #(
    parameter int AW     = 16,
    parameter int PW     = 8,
    parameter bit REV_EN = 1'b1
) (
    input  logic [PW-1:0]    page_i,
    input  logic [AW-1:0]    word_i,
    input  logic             rev_i,
    output logic [PW+AW-1:0] addr_o
);
    logic [AW-1:0] word_q;

    generate
        if (REV_EN) begin : g_rev
            logic [AW-1:0] mirror;
            for (genvar b = 0; b < AW; b++) begin : g_bit
                assign mirror[b] = word_i[AW-1-b];
            end
            assign word_q = rev_i ? mirror : word_i;
        end else begin : g_norev
            assign word_q = word_i;
        end
    endgenerate

    assign addr_o = {page_i, word_q};
endmodule

// File: rtl/paged_dag.sv
// Paged circular data address generator. Emits a 24-bit address for
// pre-modify or post-modify accesses, updates pointers, and swaps register
// sets. Assumes the immediate is narrower than the address word.
module paged_dag
    import dagp_pkg::*;
#(
    parameter int AW   = 16,
    parameter int PW   = 8,
    parameter int NREG = 4,
    parameter int IMMW = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [1:0]              op_code,
    input  logic [$clog2(NREG)-1:0] op_sel,
    input  logic                    imm_sel,
    input  logic [$clog2(NREG)-1:0] mod_sel,
    input  logic [IMMW-1:0]         imm,
    input  logic                    bitrev,
    input  logic                    wr_en,
    input  logic [1:0]              wr_file,
    input  logic [$clog2(NREG)-1:0] wr_sel,
    input  logic [AW-1:0]           wr_data,
    input  logic                    page_wr,
    input  logic [PW-1:0]           page_data,
    input  logic                    swap,
    input  logic [1:0]              rd_file,
    input  logic [$clog2(NREG)-1:0] rd_sel,
    output logic [AW-1:0]           rd_data,
    output logic                    addr_valid,
    output logic [PW+AW-1:0]        addr
);
    localparam int XW = AW - IMMW;

    logic [AW-1:0] idx_q [NREG], mod_q [NREG], len_q [NREG], base_q [NREG];
    logic [AW-1:0] sec_idx [NREG];
    logic [PW-1:0] page_q;
    logic [AW-1:0] modv, cur, wrapped, emit;
    logic          upd_en;
    dag_op_e       op;

    assign op = dag_op_e'(op_code);

    dagp_bank #(.AW(AW), .PW(PW), .NREG(NREG)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_file   (wr_file),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .page_wr   (page_wr),
        .page_data (page_data),
        .upd_en    (upd_en),
        .upd_sel   (op_sel),
        .upd_val   (wrapped),
        .swap      (swap),
        .idx_o     (idx_q),
        .mod_o     (mod_q),
        .len_o     (len_q),
        .base_o    (base_q),
        .page_o    (page_q),
        .sec_idx_o (sec_idx)
    );

    // Choose the modifier: sign-extended immediate or a modify register.
    assign modv = imm_sel ? {{XW{imm[IMMW-1]}}, imm} : mod_q[mod_sel];
    assign cur  = idx_q[op_sel];

    dagp_wrap #(.AW(AW)) u_wrap (
        .idx_i  (cur),
        .mod_i  (modv),
        .base_i (base_q[op_sel]),
        .len_i  (len_q[op_sel]),
        .nxt_o  (wrapped)
    );

    // Decode the operation into an emitted word and update strobe.
    always_comb begin
        emit       = cur;
        upd_en     = 1'b0;
        addr_valid = 1'b0;
        case (op)
            OP_PRE:  begin emit = wrapped; addr_valid = 1'b1; end
            OP_POST: begin upd_en = 1'b1;  addr_valid = 1'b1; end
            OP_MOD:  upd_en = 1'b1;
            default: ;
        endcase
    end

    dagp_fmt #(.AW(AW), .PW(PW), .REV_EN(1'b1)) u_fmt (
        .page_i (page_q),
        .word_i (emit),
        .rev_i  (bitrev),
        .addr_o (addr)
    );

    // Combinational readback of the working set.
    always_comb begin
        case (dag_file_e'(rd_file))
            RF_INDEX:  rd_data = idx_q[rd_sel];
            RF_MODIFY: rd_data = mod_q[rd_sel];
            RF_LENGTH: rd_data = len_q[rd_sel];
            default:   rd_data = base_q[rd_sel];
        endcase
    end
endmodule

// File: rtl/paged_dag_chk.sv
// Temporal checks for paged_dag, attached through bind.
module paged_dag_chk #(
    parameter int AW   = 16,
    parameter int PW   = 8,
    parameter int NREG = 4,
    parameter int IMMW = 8
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [1:0]              op_code,
    input logic [$clog2(NREG)-1:0] op_sel,
    input logic                    imm_sel,
    input logic [IMMW-1:0]         imm,
    input logic                    bitrev,
    input logic                    wr_en,
    input logic                    page_wr,
    input logic [PW-1:0]           page_data,
    input logic                    swap,
    input logic                    addr_valid,
    input logic [PW+AW-1:0]        addr,
    input logic [AW-1:0]           idx_q   [NREG],
    input logic [AW-1:0]           len_q   [NREG],
    input logic [AW-1:0]           base_q  [NREG],
    input logic [AW-1:0]           sec_idx [NREG]
);
    logic [IMMW-1:0] imm_mag;
    logic [AW:0]     sel_hi;
    logic            sel_in;

    assign imm_mag = imm[IMMW-1] ? -imm : imm;
    assign sel_hi  = {1'b0, base_q[op_sel]} + {1'b0, len_q[op_sel]};
    assign sel_in  = (idx_q[op_sel] >= base_q[op_sel]) && ({1'b0, idx_q[op_sel]} < sel_hi);

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        !rst_n |=> (idx_q[0] == '0 && sec_idx[0] == '0));

    // R2
    pre_keeps_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == 2'd0 && !wr_en && !swap)
        |=> idx_q[$past(op_sel)] == $past(idx_q[op_sel]));

    // R3
    post_emits_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == 2'd1 && !bitrev) |-> (addr_valid && addr[AW-1:0] == idx_q[op_sel]));

    // R5
    modify_no_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == 2'd2 || op_code == 2'd3) |-> !addr_valid);

    // R6
    wrap_stays_in_buffer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((op_code == 2'd1 || op_code == 2'd2) && imm_sel && len_q[op_sel] != '0
         && sel_in && {{(AW-IMMW){1'b0}}, imm_mag} < len_q[op_sel] && !wr_en && !swap)
        |=> (idx_q[$past(op_sel)] >= base_q[$past(op_sel)]
             && {1'b0, idx_q[$past(op_sel)]}
                < ({1'b0, base_q[$past(op_sel)]} + {1'b0, len_q[$past(op_sel)]})));

    // R8
    page_follows_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (page_wr && !swap) |=> (!addr_valid || addr[PW+AW-1:AW] == $past(page_data)));

    // R10
    swap_exchanges_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (swap && !wr_en && op_code == 2'd3)
        |=> (idx_q[0] == $past(sec_idx[0]) && sec_idx[0] == $past(idx_q[0])));
endmodule

bind paged_dag paged_dag_chk #(.AW(AW), .PW(PW), .NREG(NREG), .IMMW(IMMW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_code    (op_code),
    .op_sel     (op_sel),
    .imm_sel    (imm_sel),
    .imm        (imm),
    .bitrev     (bitrev),
    .wr_en      (wr_en),
    .page_wr    (page_wr),
    .page_data  (page_data),
    .swap       (swap),
    .addr_valid (addr_valid),
    .addr       (addr),
    .idx_q      (idx_q),
    .len_q      (len_q),
    .base_q     (base_q),
    .sec_idx    (sec_idx)
);

// File: tb/paged_dag_bench.sv
module paged_dag_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  op_code = 2'd3;
    logic [1:0]  op_sel = '0;
    logic        imm_sel = 1'b0;
    logic [1:0]  mod_sel = '0;
    logic [7:0]  imm = '0;
    logic        bitrev = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_file = '0;
    logic [1:0]  wr_sel = '0;
    logic [15:0] wr_data = '0;
    logic        page_wr = 1'b0;
    logic [7:0]  page_data = '0;
    logic        swap = 1'b0;
    logic [1:0]  rd_file = '0;
    logic [1:0]  rd_sel = '0;
    logic [15:0] rd_data;
    logic        addr_valid;
    logic [23:0] addr;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    paged_dag u_paged_dag (
        .clk(clk), .rst_n(rst_n), .op_code(op_code), .op_sel(op_sel),
        .imm_sel(imm_sel), .mod_sel(mod_sel), .imm(imm), .bitrev(bitrev),
        .wr_en(wr_en), .wr_file(wr_file), .wr_sel(wr_sel), .wr_data(wr_data),
        .page_wr(page_wr), .page_data(page_data), .swap(swap),
        .rd_file(rd_file), .rd_sel(rd_sel), .rd_data(rd_data),
        .addr_valid(addr_valid), .addr(addr)
    );

    // {kind, sel, imm_sel, mod_sel, imm, bitrev, exp_valid, exp_addr}
    function automatic logic [40:0] mk(input logic [1:0] k, input logic [1:0] s,
                                       input logic is, input logic [1:0] ms,
                                       input logic [7:0] im, input logic br,
                                       input logic ev, input logic [23:0] ea);
        return {k, s, is, ms, im, br, ev, ea};
    endfunction

    localparam int NV = 14;
    localparam logic [40:0] VEC [NV] = '{
        mk(2'd0, 2'd0, 1'b0, 2'd0, 8'h00, 1'b0, 1'b1, 24'h3C1004), // R2
        mk(2'd1, 2'd0, 1'b0, 2'd0, 8'h00, 1'b0, 1'b1, 24'h3C1000), // R3
        mk(2'd1, 2'd0, 1'b1, 2'd0, 8'hF8, 1'b0, 1'b1, 24'h3C1004), // R4 negative imm
        mk(2'd0, 2'd0, 1'b1, 2'd0, 8'h7F, 1'b0, 1'b1, 24'h3C107B), // R4 max imm
        mk(2'd1, 2'd1, 1'b0, 2'd1, 8'h00, 1'b0, 1'b1, 24'h3C0105), // R6 wrap high
        mk(2'd1, 2'd1, 1'b0, 2'd1, 8'h00, 1'b0, 1'b1, 24'h3C0100), // R6
        mk(2'd0, 2'd1, 1'b1, 2'd0, 8'hFC, 1'b0, 1'b1, 24'h3C0107), // R6 wrap low
        mk(2'd2, 2'd1, 1'b1, 2'd0, 8'hFC, 1'b0, 1'b0, 24'h000000), // R5
        mk(2'd0, 2'd1, 1'b0, 2'd1, 8'h00, 1'b0, 1'b1, 24'h3C0102), // R6
        mk(2'd1, 2'd2, 1'b0, 2'd2, 8'h00, 1'b0, 1'b1, 24'h3CFFFE), // R7
        mk(2'd0, 2'd2, 1'b1, 2'd0, 8'hFB, 1'b0, 1'b1, 24'h3CFFFE), // R7
        mk(2'd1, 2'd3, 1'b0, 2'd3, 8'h00, 1'b1, 1'b1, 24'h3C0000), // R9
        mk(2'd1, 2'd3, 1'b0, 2'd3, 8'h00, 1'b1, 1'b1, 24'h3C8000), // R9
        mk(2'd0, 2'd3, 1'b1, 2'd0, 8'h01, 1'b1, 1'b1, 24'h3CC000)  // R9
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        op_code = 2'd3; wr_en = 1'b0; swap = 1'b0; page_wr = 1'b0;
        bitrev = 1'b0; imm_sel = 1'b0;
    endtask

    task automatic wreg(input logic [1:0] f, input logic [1:0] s, input logic [15:0] d);
        @(posedge clk); #1;
        idle();
        wr_en = 1'b1; wr_file = f; wr_sel = s; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [1:0] f, input logic [1:0] s,
                            input logic [15:0] exp);
        rd_file = f; rd_sel = s;
        #1;
        check(req, {16'h0, rd_data}, {16'h0, exp});
    endtask

    task automatic drive(input logic [1:0] k, input logic [1:0] s, input logic is,
                         input logic [1:0] ms, input logic [7:0] im, input logic br);
        @(posedge clk); #1;
        idle();
        op_code = k; op_sel = s; imm_sel = is; mod_sel = ms; imm = im; bitrev = br;
    endtask

    task automatic finish_op();
        @(posedge clk); #1;
        idle();
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 valid in reset", {31'h0, addr_valid}, 32'h0);
        #1; rst_n = 1'b1;
        for (int s = 0; s < 4; s++) begin
            rd_check("R1 index", 2'd0, 2'(s), 16'h0);
            rd_check("R1 length", 2'd2, 2'(s), 16'h0);
        end
        drive(2'd0, 2'd0, 1'b0, 2'd0, 8'h00, 1'b0);
        @(negedge clk);
        check("R1 addr after reset", {7'h0, addr_valid, addr}, {7'h0, 1'b1, 24'h000000});
        finish_op();

        // Load the working set.
        wreg(2'd0, 2'd0, 16'h1000); wreg(2'd1, 2'd0, 16'h0004);
        wreg(2'd0, 2'd1, 16'h0105); wreg(2'd1, 2'd1, 16'h0003);
        wreg(2'd2, 2'd1, 16'h0008); wreg(2'd3, 2'd1, 16'h0100);
        wreg(2'd0, 2'd2, 16'hFFFE); wreg(2'd1, 2'd2, 16'h0005);
        wreg(2'd1, 2'd3, 16'h0001);
        @(posedge clk); #1;
        page_wr = 1'b1; page_data = 8'h3C;
        @(posedge clk); #1;
        page_wr = 1'b0;
        rd_check("R11 readback modify", 2'd1, 2'd1, 16'h0003);
        rd_check("R11 readback base", 2'd3, 2'd1, 16'h0100);

        // Table walk.
        for (int v = 0; v < NV; v++) begin
            logic [40:0] e;
            string tag;
            e = VEC[v];
            drive(e[40:39], e[38:37], e[36], e[35:34], e[33:26], e[25]);
            tag = (e[40:39] == 2'd0) ? "R2 pre" : (e[40:39] == 2'd1) ? "R3 post" : "R5 modify";
            @(negedge clk);
            check(tag, {31'h0, addr_valid}, {31'h0, e[24]});
            if (e[24]) check(tag, {8'h0, addr}, {8'h0, e[23:0]});
            finish_op();
        end
        rd_check("R2 index after table", 2'd0, 2'd0, 16'h0FFC);
        rd_check("R6 index after table", 2'd0, 2'd1, 16'h0107);
        rd_check("R7 index after table", 2'd0, 2'd2, 16'h0003);
        rd_check("R9 stored index not mirrored", 2'd0, 2'd3, 16'h0002);

        // Swap sets.
        @(posedge clk); #1; idle(); swap = 1'b1;
        @(posedge clk); #1; swap = 1'b0;
        rd_check("R10 shadow was empty", 2'd0, 2'd0, 16'h0000);
        wreg(2'd0, 2'd0, 16'h2222);
        @(posedge clk); #1; idle(); swap = 1'b1;
        @(posedge clk); #1; swap = 1'b0;
        rd_check("R10 set restored", 2'd0, 2'd0, 16'h0FFC);

        // Post-modify in the same cycle as a swap.
        drive(2'd1, 2'd0, 1'b0, 2'd0, 8'h00, 1'b0);
        swap = 1'b1;
        @(negedge clk);
        check("R10 addr from old set", {8'h0, addr}, {8'h0, 24'h3C0FFC});
        finish_op();
        rd_check("R10 other set active", 2'd0, 2'd0, 16'h2222);
        @(posedge clk); #1; idle(); swap = 1'b1;
        @(posedge clk); #1; swap = 1'b0;
        rd_check("R10 writeback carried", 2'd0, 2'd0, 16'h1000);

        // Port write against post-modify on the same index.
        drive(2'd1, 2'd0, 1'b0, 2'd0, 8'h00, 1'b0);
        wr_en = 1'b1; wr_file = 2'd0; wr_sel = 2'd0; wr_data = 16'h5555;
        @(negedge clk);
        check("R11 addr before write", {8'h0, addr}, {8'h0, 24'h3C1000});
        finish_op();
        rd_check("R11 write wins", 2'd0, 2'd0, 16'h5555);

        // Page write timing.
        drive(2'd0, 2'd0, 1'b0, 2'd0, 8'h00, 1'b0);
        page_wr = 1'b1; page_data = 8'hA5;
        @(negedge clk);
        check("R8 old page same cycle", {8'h0, addr}, {8'h0, 24'h3C5559});
        drive(2'd0, 2'd0, 1'b0, 2'd0, 8'h00, 1'b0);
        @(negedge clk);
        check("R8 new page next cycle", {8'h0, addr}, {8'h0, 24'hA55559});
        finish_op();

        // No-op code.
        drive(2'd3, 2'd0, 1'b0, 2'd0, 8'h00, 1'b0);
        @(negedge clk);
        check("R5 no-op valid", {31'h0, addr_valid}, 32'h0);
        finish_op();
        rd_check("R5 no-op index", 2'd0, 2'd0, 16'h5555);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule